// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that one port of a memory uses in each access cycle. Each cycle the requester either supplies a fresh address, lets the block step forward from the last one, keeps the last one, or sends it back to zero. Streaming accesses can then run through consecutive locations without a new address on the bus every cycle. Three active-low controls select the operation: a clear, a load strobe and a step enable. They resolve in a fixed order. Clear beats load, and load beats step.

The external address and all three controls are registered on the same rising edge. The resolved operation updates the counter register on the following edge. That register is the internal access address, so the result appears one cycle after capture and lines up with a registered memory read. Because every outcome is written into the counter, the value that leaves the block is always the address the access uses, whether it came from the pins, from the increment or from a clear. The counter covers the whole address space and rolls over from the top address to zero. A clear cycle is an ordinary access cycle at address 0, with no dead cycle.

The decoded operation is an enumerated state: HOLD, STEP, LOAD or CLEAR. HOLD applies when all three controls are high. STEP applies when only the step enable is low. LOAD applies when the strobe is low and the clear is high. CLEAR applies whenever the clear is low. Transitions are taken each cycle with no history: CLEAR leads to address 0, LOAD leads to the external address, STEP leads to the old address plus one, and HOLD keeps the old address.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `acc_addr` is 0 until the first operation that changes it takes effect.
- R2: When `clr_n` is low at a capturing edge, `acc_addr` is 0 one cycle later, whatever `ld_n`, `step_n` and `ext_addr` were.
- R3: When `ld_n` is low and `clr_n` is high at a capturing edge, `acc_addr` equals the captured `ext_addr` one cycle later.
- R4: When `clr_n` and `ld_n` are high and `step_n` is low at a capturing edge, `acc_addr` becomes its previous value plus one one cycle later.
- R5: When all three controls are high at a capturing edge, `acc_addr` keeps its value and `ext_addr` has no effect.
- R6: `step_n` has no effect when `ld_n` or `clr_n` is low: a load with the step enable low yields exactly the external address, and a clear with it low yields 0.
- R7: Stepping from the all-ones address (2^ADDR_W - 1) yields address 0.
- R8: Operations may be issued on back-to-back cycles. Each one is reflected in `acc_addr` one cycle after its capture, with no dead cycles, including a clear cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | Address offered by the requester |
| ld_n | input | 1 | Load strobe, active low |
| step_n | input | 1 | Step enable, active low |
| clr_n | input | 1 | Counter clear, active low |
| acc_addr | output | ADDR_W | Internal address used for the access |

## Verification
The bench builds the block with the default 14-bit address, giving a space of 16384 locations. That width is small enough to load 16382 and step across the top of the space and back to zero in a handful of cycles. It is still wide enough to show that an increment on a low address never spills into a stray high bit. Streams of one operation per cycle exercise the one-cycle capture latency with nothing idle between operations.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } bag_op_e;

endpackage

// File: rtl/bag_capture.sv
module bag_capture #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_ld_n,
    output logic              cap_step_n,
    output logic              cap_clr_n
);

    // Controls reset to their inactive level so the first resolved op is HOLD.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr   <= '0;
            cap_ld_n   <= 1'b1;
            cap_step_n <= 1'b1;
            cap_clr_n  <= 1'b1;
        end else begin
            cap_addr   <= ext_addr;
            cap_ld_n   <= ld_n;
            cap_step_n <= step_n;
            cap_clr_n  <= clr_n;
        end
    end

endmodule

// File: rtl/bag_decode.sv
module bag_decode
    import burst_addr_pkg::*;
(
    input  logic    cap_ld_n,
    input  logic    cap_step_n,
    input  logic    cap_clr_n,
    output bag_op_e op
);

    // Fixed priority: clear, then load, then step.
    always_comb begin
        unique casez ({cap_clr_n, cap_ld_n, cap_step_n})
            3'b0??:  op = OP_CLEAR;
            3'b10?:  op = OP_LOAD;
            3'b110:  op = OP_STEP;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/bag_counter.sv
module bag_counter
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bag_op_e           op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cnt_q
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] cnt_d;

    // Next-value selection; the ADDR_W-bit add rolls over naturally.
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = load_addr;
            OP_STEP:  cnt_d = cnt_q + ONE;
            OP_HOLD:  cnt_d = cnt_q;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] cap_addr;
    logic              cap_ld_n;
    logic              cap_step_n;
    logic              cap_clr_n;
    bag_op_e           op;

    bag_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_addr   (ext_addr),
        .ld_n       (ld_n),
        .step_n     (step_n),
        .clr_n      (clr_n),
        .cap_addr   (cap_addr),
        .cap_ld_n   (cap_ld_n),
        .cap_step_n (cap_step_n),
        .cap_clr_n  (cap_clr_n)
    );

    bag_decode u_dec (
        .cap_ld_n   (cap_ld_n),
        .cap_step_n (cap_step_n),
        .cap_clr_n  (cap_clr_n),
        .op         (op)
    );

    bag_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_addr (cap_addr),
        .cnt_q     (acc_addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ld_n,
    input logic              step_n,
    input logic              clr_n,
    input logic [ADDR_W-1:0] acc_addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Edges seen since reset release; properties need two edges of history.
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 3)  warm <= warm + 2'd1;
    end
    logic hist_ok;
    assign hist_ok = (warm == 2'd3);

    always_comb begin
        if (!rst_n) a_r1_reset_zero: assert (acc_addr == '0);
    end

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(clr_n, 2)) |-> (acc_addr == '0));

    a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(clr_n, 2) && !$past(ld_n, 2))
            |-> (acc_addr == $past(ext_addr, 2)));

    a_r4_r7_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(clr_n, 2) && $past(ld_n, 2) && !$past(step_n, 2))
            |-> (acc_addr == $past(acc_addr) + ONE));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(clr_n, 2) && $past(ld_n, 2) && $past(step_n, 2))
            |-> $stable(acc_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .ld_n     (ld_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .acc_addr (acc_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int AW = 14;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          ld_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] acc_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_addr (ext_addr),
        .ld_n     (ld_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .acc_addr (acc_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] exp);
        n_chk++;
        if (acc_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: acc_addr=%0d expected=%0d", tag, acc_addr, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic s,
                         input logic [AW-1:0] a);
        clr_n = c; ld_n = l; step_n = s; ext_addr = a;
    endtask

    // One operation followed by idle; result checked one cycle after capture.
    task automatic one_op(input logic c, input logic l, input logic s,
                          input logic [AW-1:0] a, input logic [AW-1:0] exp,
                          input string tag);
        drive(c, l, s, a);
        @(posedge clk); @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, ~a);
        @(posedge clk); @(negedge clk);
        check(tag, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 during reset", '0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R1 after release", '0);
    endtask

    task automatic t_load_step_hold;
        one_op(1, 0, 1, 14'd100, 14'd100, "R3 load");
        one_op(1, 1, 0, 14'h3AAA, 14'd101, "R4 step one");
        one_op(1, 1, 0, '0, 14'd102, "R4 step two");
        one_op(1, 1, 1, 14'd7, 14'd102, "R5 hold ignores ext");
        one_op(1, 1, 1, 14'h1234, 14'd102, "R5 hold again");
    endtask

    task automatic t_priority;
        one_op(1, 0, 0, 14'd500, 14'd500, "R6 load beats step");
        one_op(0, 0, 0, 14'd900, '0, "R2 R6 clear beats all");
        one_op(1, 0, 1, 14'd42, 14'd42, "R3 reload");
        one_op(0, 1, 1, 14'd77, '0, "R2 clear alone");
        one_op(0, 0, 1, 14'd33, '0, "R2 clear beats load");
    endtask

    task automatic t_wrap;
        one_op(1, 0, 1, TOP - 14'd1, TOP - 14'd1, "R3 load near top");
        one_op(1, 1, 0, '0, TOP, "R7 step to top");
        one_op(1, 1, 0, '0, '0, "R7 wrap to zero");
        one_op(1, 1, 0, '0, 14'd1, "R7 step after wrap");
    endtask

    // Back-to-back: load, four steps, clear, step, load, hold on consecutive edges.
    task automatic t_stream;
        logic [AW-1:0] exp_q [$];
        drive(1, 0, 1, 14'd200); exp_q.push_back(14'd200);
        @(posedge clk); @(negedge clk);
        for (int i = 1; i <= 9; i++) begin
            case (i)
                1, 2, 3, 4: begin drive(1, 1, 0, 14'd3); exp_q.push_back(14'd200 + 14'(i)); end
                5:          begin drive(0, 1, 0, 14'd3); exp_q.push_back('0); end
                6:          begin drive(1, 1, 0, 14'd3); exp_q.push_back(14'd1); end
                7:          begin drive(1, 0, 0, 14'd60); exp_q.push_back(14'd60); end
                default:    begin drive(1, 1, 1, 14'd9); exp_q.push_back(14'd60); end
            endcase
            @(posedge clk); @(negedge clk);
            check("R8 stream", exp_q.pop_front());
        end
        drive(1, 1, 1, '0);
        @(posedge clk); @(negedge clk);
        check("R8 stream tail", exp_q.pop_front());
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_load_step_hold();
        t_priority();
        t_wrap();
        t_stream();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule